// File: doc/BRIEF.md
# Receive Timestamp Snapshot Unit for Precision Time Protocol

This block holds the receive-side timestamps for several Ethernet channels that take part in precision time protocol exchanges. A free-running system time value is shared by all channels. Each channel has a message-received strobe and a message-type code that an upstream parser supplies. When the strobe comes with the message type that fits the channel's role, the block stores the current system time in that channel's snapshot and raises a sticky event flag. In the master role that message is a delay request. In the slave role it is a sync message.

While the flag is up, the snapshot is frozen. Software can therefore read the low and high 32-bit halves in either order and still get one consistent 64-bit value. Software clears the flag by writing a one to it, and that re-arms the channel. The register interface is a simple 32-bit word bus. The write strobe acts in the same clock cycle. The read data comes either straight from the address decode or one cycle later, as a parameter selects. Each channel has its own block of four words, and consecutive channels sit a fixed stride apart.

Top module: `rxts_capture_unit`

## Requirements
- R1: A channel in the slave role (control bit 0 = 0) captures on a strobe whose message-type code is 4'h0 (sync). A strobe with code 4'h1 (delay request) does not capture.
- R2: A channel in the master role (control bit 0 = 1) captures on a strobe with code 4'h1. A strobe with code 4'h0 does not capture. Any other code, such as 4'h8, never captures in either role.
- R3: The captured value equals the system time present in the cycle the strobe is high. Bits 31:0 read from the low snapshot word and bits 63:32 read from the high snapshot word.
- R4: A capture sets the channel's event flag, which reads as bit 0 of its event word. The flag stays set until software clears it.
- R5: While the event flag is set, further qualifying strobes are ignored and the snapshot does not change.
- R6: Writing a word with bit 0 = 1 to the event word clears the flag. Writing bit 0 = 0 has no effect. Clearing leaves the held snapshot readable and unchanged.
- R7: When a clearing write and a qualifying strobe fall in the same cycle, the clear acts first. The new time is captured and the flag reads as set.
- R8: After reset every snapshot, event flag and role bit reads as zero. Writes to the snapshot words are ignored.
- R9: Channel n uses the control word at byte offset 0x040 + 0x20*n, the event word at 0x044 + 0x20*n, the low snapshot at 0x050 + 0x20*n and the high snapshot at 0x054 + 0x20*n. The control word reads back its role bit in bit 0. Any other address reads as zero. Channels act independently.
- R10: With READ_PIPE = 1, read data appears on the clock edge after the address is presented. With READ_PIPE = 0, read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | TIME_W (64) | Free-running system time |
| rx_stb | input | NUM_CH (8) | One-cycle message-received strobe per channel |
| rx_msg_type | input | NUM_CH*MSG_W (32) | Message-type code per channel, channel n in bits n*MSG_W upward |
| reg_addr | input | ADDR_W (12) | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench builds the block with eight channels, 64-bit time, a 12-bit address and READ_PIPE = 1. With these values the top channel's high snapshot at 0x134 can be addressed, and so can an unmapped word just past the last channel at 0x148. The registered read path is also covered, and its one-cycle latency is observed directly. Two-word halves with distinct patterns show that the low and high halves are not swapped. Time changes right after each strobe, so a capture taken one cycle late would show up.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
   // per-channel word offsets inside one channel block
   localparam int unsigned OFF_CTRL    = 'h00;
   localparam int unsigned OFF_EVT     = 'h04;
   localparam int unsigned OFF_SNAP_LO = 'h10;
   localparam int unsigned OFF_SNAP_HI = 'h14;
   localparam int unsigned CH_SPAN     = 'h18;

   // precision time protocol message type codes
   localparam logic [3:0] MSG_SYNC      = 4'h0;
   localparam logic [3:0] MSG_DELAY_REQ = 4'h1;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } role_e;
endpackage

// File: rtl/rxts_trig_match.sv
module rxts_trig_match
   import rxts_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned MSG_W  = 4
) (
   input  logic [NUM_CH-1:0]       stb,
   input  logic [NUM_CH*MSG_W-1:0] msg_type,
   input  logic [NUM_CH-1:0]       role,
   output logic [NUM_CH-1:0]       trig
);
   localparam logic [MSG_W-1:0] CODE_SYNC = MSG_W'(MSG_SYNC);
   localparam logic [MSG_W-1:0] CODE_DREQ = MSG_W'(MSG_DELAY_REQ);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [MSG_W-1:0] code;
      logic             want;
      assign code = msg_type[c*MSG_W +: MSG_W];
      always_comb begin
         if (role_e'(role[c]) == ROLE_MASTER) want = (code == CODE_DREQ);
         else                                 want = (code == CODE_SYNC);
      end
      assign trig[c] = stb[c] & want;
   end
endmodule

// File: rtl/rxts_snap_chan.sv
module rxts_snap_chan
   import rxts_pkg::*;
#(
   parameter int unsigned TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              trig,
   input  logic              clr,
   input  logic              role_we,
   input  logic              role_wd,
   output logic              role,
   output logic              rxs,
   output logic [TIME_W-1:0] snap
);
   role_e role_q;
   logic  rxs_after_clr;
   logic  take;

   // the clear acts first, then a trigger may load again
   assign rxs_after_clr = rxs & ~clr;
   assign take          = trig & ~rxs_after_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         role_q <= ROLE_SLAVE;
         rxs    <= 1'b0;
         snap   <= '0;
      end else begin
         if (role_we) role_q <= role_e'(role_wd);
         rxs <= rxs_after_clr | take;
         if (take) snap <= sys_time;
      end
   end

   assign role = role_q;
endmodule

// File: rtl/rxts_reg_if.sv
module rxts_reg_if
   import rxts_pkg::*;
#(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned CH_BASE   = 'h040,
   parameter int unsigned CH_STRIDE = 'h20,
   parameter bit          READ_PIPE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr,
   input  logic [31:0]              wdata,
   input  logic [NUM_CH-1:0]        role,
   input  logic [NUM_CH-1:0]        rxs,
   input  logic [NUM_CH*TIME_W-1:0] snap_flat,
   output logic [NUM_CH-1:0]        clr,
   output logic [NUM_CH-1:0]        role_we,
   output logic                     role_wd,
   output logic [31:0]              rdata
);
   logic [NUM_CH-1:0] hit_ctl, hit_evt, hit_lo, hit_hi;
   logic [63:0]       snap64 [NUM_CH];
   logic [31:0]       rd_next;
   logic              unused_wbits;

   assign unused_wbits = ^wdata[31:1];
   assign role_wd      = wdata[0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      localparam int unsigned CB = CH_BASE + c * CH_STRIDE;
      assign hit_ctl[c] = (addr == ADDR_W'(CB + OFF_CTRL));
      assign hit_evt[c] = (addr == ADDR_W'(CB + OFF_EVT));
      assign hit_lo[c]  = (addr == ADDR_W'(CB + OFF_SNAP_LO));
      assign hit_hi[c]  = (addr == ADDR_W'(CB + OFF_SNAP_HI));
      assign clr[c]     = wr & hit_evt[c] & wdata[0];
      assign role_we[c] = wr & hit_ctl[c];
      always_comb begin
         snap64[c]             = '0;
         snap64[c][TIME_W-1:0] = snap_flat[c*TIME_W +: TIME_W];
      end
   end

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (hit_ctl[c]) rd_next = {31'b0, role[c]};
         if (hit_evt[c]) rd_next = {31'b0, rxs[c]};
         if (hit_lo[c])  rd_next = snap64[c][31:0];
         if (hit_hi[c])  rd_next = snap64[c][63:32];
      end
   end

   if (READ_PIPE) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_next;
      end
   end else begin : g_rd_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata      = rd_next;
   end
endmodule

// File: rtl/rxts_capture_unit.sv
module rxts_capture_unit
   import rxts_pkg::*;
#(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned MSG_W     = 4,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned CH_BASE   = 'h040,
   parameter int unsigned CH_STRIDE = 'h20,
   parameter bit          READ_PIPE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TIME_W-1:0]       sys_time,
   input  logic [NUM_CH-1:0]       rx_stb,
   input  logic [NUM_CH*MSG_W-1:0] rx_msg_type,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic                    reg_wr,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata
);
   localparam int unsigned MAP_END = CH_BASE + NUM_CH * CH_STRIDE;

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (TIME_W <= 32 || TIME_W > 64) begin : g_bad_time
      $error("TIME_W must span two words");
   end
   if (MSG_W < 4) begin : g_bad_msg
      $error("MSG_W too narrow for message codes");
   end
   if ((CH_STRIDE & (CH_STRIDE - 1)) != 0 || CH_STRIDE < CH_SPAN) begin : g_bad_stride
      $error("CH_STRIDE must be a power of two covering a channel");
   end
   if (MAP_END > (1 << ADDR_W) || (CH_BASE % 4) != 0) begin : g_bad_map
      $error("register map does not fit ADDR_W");
   end

   logic [NUM_CH-1:0]        trig_vec, clr_vec, role_we, role_vec, rxs_vec;
   logic                     role_wd;
   logic [NUM_CH*TIME_W-1:0] snap_flat;

   rxts_trig_match #(.NUM_CH(NUM_CH), .MSG_W(MSG_W)) u_match (
      .stb      (rx_stb),
      .msg_type (rx_msg_type),
      .role     (role_vec),
      .trig     (trig_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      rxts_snap_chan #(.TIME_W(TIME_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sys_time (sys_time),
         .trig     (trig_vec[c]),
         .clr      (clr_vec[c]),
         .role_we  (role_we[c]),
         .role_wd  (role_wd),
         .role     (role_vec[c]),
         .rxs      (rxs_vec[c]),
         .snap     (snap_flat[c*TIME_W +: TIME_W])
      );
   end

   rxts_reg_if #(
      .NUM_CH(NUM_CH), .TIME_W(TIME_W), .ADDR_W(ADDR_W),
      .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE), .READ_PIPE(READ_PIPE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .role      (role_vec),
      .rxs       (rxs_vec),
      .snap_flat (snap_flat),
      .clr       (clr_vec),
      .role_we   (role_we),
      .role_wd   (role_wd),
      .rdata     (reg_rdata)
   );
endmodule

// File: rtl/rxts_capture_chk.sv
module rxts_capture_chk #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned TIME_W = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [TIME_W-1:0]        sys_time,
   input logic [NUM_CH-1:0]        trig,
   input logic [NUM_CH-1:0]        clr,
   input logic [NUM_CH-1:0]        rxs,
   input logic [NUM_CH*TIME_W-1:0] snap
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R3 R7
      capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[c] && (!rxs[c] || clr[c])) |=>
            (rxs[c] && snap[c*TIME_W +: TIME_W] == $past(sys_time)));
      // R5
      snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rxs[c] && !clr[c]) |=> $stable(snap[c*TIME_W +: TIME_W]));
      // R4
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rxs[c] && !clr[c]) |=> rxs[c]);
      // R6
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[c] && !trig[c]) |=> !rxs[c]);
      // R4
      flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rxs[c]) |-> $past(trig[c]));
   end
endmodule

bind rxts_capture_unit rxts_capture_chk #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sys_time (sys_time),
   .trig     (trig_vec),
   .clr      (clr_vec),
   .rxs      (rxs_vec),
   .snap     (snap_flat)
);

// File: tb/tb_rxts_capture_unit.sv
`timescale 1ns/1ps
module tb_rxts_capture_unit;
   localparam int NCH = 8;
   localparam logic [3:0] T_SYNC = 4'h0, T_DREQ = 4'h1, T_FUP = 4'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] sys_time = '0;
   logic [NCH-1:0]   rx_stb = '0;
   logic [NCH*4-1:0] rx_msg_type = '0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rxts_capture_unit #(.NUM_CH(NCH), .TIME_W(64), .MSG_W(4), .ADDR_W(12),
      .CH_BASE('h040), .CH_STRIDE('h20), .READ_PIPE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .rx_stb(rx_stb),
      .rx_msg_type(rx_msg_type), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   function automatic logic [11:0] a_ctl(int ch); return 12'(32'h040 + 32'h20*ch); endfunction
   function automatic logic [11:0] a_evt(int ch); return 12'(32'h044 + 32'h20*ch); endfunction
   function automatic logic [11:0] a_lo(int ch);  return 12'(32'h050 + 32'h20*ch); endfunction
   function automatic logic [11:0] a_hi(int ch);  return 12'(32'h054 + 32'h20*ch); endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a;
      @(negedge clk); d = reg_rdata;
   endtask

   task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic pulse(int ch, logic [3:0] code, logic [63:0] t);
      @(negedge clk);
      sys_time = t; rx_stb[ch] = 1'b1; rx_msg_type[ch*4 +: 4] = code;
      @(negedge clk);
      rx_stb[ch] = 1'b0; sys_time = t + 64'h0000_0101_0000_0101;
   endtask

   task automatic t_reset();
      rd_chk("R8 ctl0",  a_ctl(0), 32'h0);
      rd_chk("R8 evt0",  a_evt(0), 32'h0);
      rd_chk("R8 lo0",   a_lo(0),  32'h0);
      rd_chk("R8 hi0",   a_hi(0),  32'h0);
      rd_chk("R8 hi7",   a_hi(7),  32'h0);
   endtask

   task automatic t_slave();
      pulse(0, T_SYNC, 64'h1111_2222_3333_4444);
      rd_chk("R3 lo",       a_lo(0),  32'h3333_4444);
      rd_chk("R3 hi",       a_hi(0),  32'h1111_2222);
      rd_chk("R1 R4 evt",   a_evt(0), 32'h1);
      pulse(1, T_DREQ, 64'h5555_6666_7777_8888);
      rd_chk("R1 dreq evt", a_evt(1), 32'h0);
      rd_chk("R1 dreq lo",  a_lo(1),  32'h0);
   endtask

   task automatic t_master();
      wr(a_ctl(2), 32'h1);
      rd_chk("R9 ctl rb", a_ctl(2), 32'h1);
      pulse(2, T_DREQ, 64'hAAAA_BBBB_CCCC_DDDD);
      rd_chk("R2 evt",    a_evt(2), 32'h1);
      rd_chk("R2 hi",     a_hi(2),  32'hAAAA_BBBB);
      wr(a_ctl(3), 32'h1);
      pulse(3, T_SYNC, 64'h1234_5678_9ABC_DEF0);
      rd_chk("R2 sync ignored", a_evt(3), 32'h0);
      pulse(3, T_FUP, 64'h1234_5678_9ABC_DEF0);
      rd_chk("R2 other code",   a_evt(3), 32'h0);
      pulse(0, T_FUP, 64'h0);
      rd_chk("R2 other code slave", a_lo(0), 32'h3333_4444);
   endtask

   task automatic t_lock_clear();
      pulse(0, T_SYNC, 64'h0F0F_0F0F_F0F0_F0F0);
      rd_chk("R5 lo held", a_lo(0), 32'h3333_4444);
      rd_chk("R5 hi held", a_hi(0), 32'h1111_2222);
      wr(a_evt(0), 32'hFFFF_FFFE);
      rd_chk("R6 w0 no effect", a_evt(0), 32'h1);
      wr(a_evt(0), 32'h1);
      rd_chk("R6 w1 clears",    a_evt(0), 32'h0);
      rd_chk("R6 snap kept",    a_lo(0),  32'h3333_4444);
      pulse(0, T_SYNC, 64'h2222_0000_0000_2222);
      rd_chk("R4 rearmed lo",   a_lo(0),  32'h0000_2222);
      rd_chk("R4 rearmed evt",  a_evt(0), 32'h1);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      reg_addr = a_evt(0); reg_wdata = 32'h1; reg_wr = 1'b1;
      sys_time = 64'h7777_1111_7777_2222; rx_stb[0] = 1'b1; rx_msg_type[3:0] = T_SYNC;
      @(negedge clk);
      reg_wr = 1'b0; rx_stb[0] = 1'b0; sys_time = 64'h0;
      rd_chk("R7 evt set", a_evt(0), 32'h1);
      rd_chk("R7 new lo",  a_lo(0),  32'h7777_2222);
      rd_chk("R7 new hi",  a_hi(0),  32'h7777_1111);
   endtask

   task automatic t_ro_map();
      wr(a_lo(0), 32'hDEAD_BEEF);
      wr(a_hi(0), 32'hCAFE_F00D);
      rd_chk("R8 lo ro", a_lo(0), 32'h7777_2222);
      rd_chk("R8 hi ro", a_hi(0), 32'h7777_1111);
      pulse(7, T_SYNC, 64'h9876_5432_0123_4567);
      rd_chk("R9 lo7 0x130", 12'h130, 32'h0123_4567);
      rd_chk("R9 hi7 0x134", 12'h134, 32'h9876_5432);
      rd_chk("R9 unmapped 0x000", 12'h000, 32'h0);
      rd_chk("R9 unmapped 0x148", 12'h148, 32'h0);
      rd_chk("R9 ch6 independent", a_evt(6), 32'h0);
   endtask

   task automatic t_latency();
      logic [31:0] d;
      rd(12'h134, d);
      @(negedge clk); reg_addr = 12'h130;
      #1 chk("R10 old data before edge", reg_rdata, 32'h9876_5432);
      @(negedge clk);
      chk("R10 new data after edge", reg_rdata, 32'h0123_4567);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_slave();
      t_master();
      t_lock_clear();
      t_same_cycle();
      t_ro_map();
      t_latency();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule